// File: doc/BRIEF.md
# Host Link Status LED Encoder

This block turns the health of a board's host-bus connection into a pattern on one tricolour indicator. It reads four facts: which firmware image is running (none, the normal image or the safe fallback image), whether the link trained at the second-generation or the first-generation speed, whether all four lanes came up, and whether link training failed. From these it picks a colour and a pattern. The colour shows which image runs. Solid or flashing shows the speed. A training failure gets a flashing red of its own.

The status inputs are sampled on every clock. A fixed priority decoder maps the sampled status to a colour and to a flash flag. A prescaled flash generator produces a slow square wave with equal on and off halves. Any change in the sampled status restarts that wave at the beginning of its lit half. This way a new pattern always begins with a full lit pulse and never with a clipped one. The red, green and blue enables drive the LED drivers directly.

Top module: `host_link_led`

## Requirements
- R1: When the firmware code is 2'b00 (no image) or the reserved code 2'b11, the LED is solid red. This holds whatever the speed, lane-width and training-failure inputs are.
- R2: With an image loaded (code 2'b01 or 2'b10) and the training-failure input high, the LED flashes red. This overrides speed, lane width and image type.
- R3: With the normal image (code 2'b01), no failure, second-generation speed (gen2 input = 1) and four lanes (x4 input = 1), the LED is solid green.
- R4: With the normal image, no failure, first-generation speed (gen2 input = 0) and four lanes, the LED flashes green.
- R5: With the normal image, no failure and fewer than four lanes (x4 input = 0), the LED is amber: red and green enabled together. It is solid at second-generation speed and flashing at first-generation speed.
- R6: With the safe image (code 2'b10) and no failure, the LED is blue. It is solid at second-generation speed and flashing at first-generation speed, and the lane-width input has no effect on it. Blue is never lit together with red or green.
- R7: A flashing LED is lit for HALF clock cycles and then dark for HALF clock cycles, repeating, where HALF = CLK_HZ / (2 * FLASH_HZ).
- R8: Inputs are sampled at each rising clock edge, and the outputs show the status sampled at the most recent edge. When the sampled status differs from the previous sample, the flash wave restarts at the first cycle of its lit half. This also holds if the change arrives on the same edge on which the wave would have toggled.
- R9: While reset is asserted (rst_n low, asynchronous), the sampled status is cleared to firmware code 2'b00 and the wave is put in its lit half, so the LED is solid red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_image_i | input | 2 | Firmware image code: 00 none, 01 normal, 10 safe, 11 reserved |
| link_gen2_i | input | 1 | 1 = second-generation link speed, 0 = first-generation |
| lanes_x4_i | input | 1 | 1 = all four lanes trained |
| train_fail_i | input | 1 | Link training failed |
| led_red_o | output | 1 | Red enable |
| led_green_o | output | 1 | Green enable |
| led_blue_o | output | 1 | Blue enable |

## Verification
The flash generator can reach its half-period terminal count on the same edge that a new status is sampled. In that case the restart must win over the toggle. The bench forces this collision by watching its own model's prescaler and changing the status on exactly the cycle before the terminal edge. It does this once while the wave is lit and once while the wave is dark. The bench's behavioural model keeps its own counter and phase. It is compared with the three enables on every cycle, so a toggle that beats the restart shows up as a dark first cycle of the new pattern.

// File: rtl/host_link_led_pkg.sv
package host_link_led_pkg;

    typedef enum logic [1:0] {
        IMG_NONE   = 2'b00,
        IMG_NORMAL = 2'b01,
        IMG_SAFE   = 2'b10,
        IMG_RSVD   = 2'b11
    } fw_image_e;

    typedef struct packed {
        fw_image_e image;
        logic      gen2;
        logic      x4;
        logic      fail;
    } link_status_t;

    typedef struct packed {
        logic red;
        logic green;
        logic blue;
    } rgb_t;

    typedef struct packed {
        rgb_t colour;
        logic flash;
    } led_pattern_t;

    localparam link_status_t STATUS_RESET = '{image: IMG_NONE, gen2: 1'b0, x4: 1'b0, fail: 1'b0};

    localparam rgb_t RGB_OFF   = '{red: 1'b0, green: 1'b0, blue: 1'b0};
    localparam rgb_t RGB_RED   = '{red: 1'b1, green: 1'b0, blue: 1'b0};
    localparam rgb_t RGB_GREEN = '{red: 1'b0, green: 1'b1, blue: 1'b0};
    localparam rgb_t RGB_AMBER = '{red: 1'b1, green: 1'b1, blue: 1'b0};
    localparam rgb_t RGB_BLUE  = '{red: 1'b0, green: 1'b0, blue: 1'b1};

endpackage

// File: rtl/hll_sampler.sv
module hll_sampler
    import host_link_led_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  link_status_t status_i,
    output link_status_t status_o,
    output logic         change_o
);

    typedef struct packed {
        link_status_t status;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = status_i;
        change_o    = (status_i != st_q.status);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= STATUS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    // A flagged change must land in the sample register on the next edge.
    assert_change_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |=> (status_o != $past(status_o)));

endmodule

// File: rtl/hll_priority.sv
module hll_priority
    import host_link_led_pkg::*;
(
    input  link_status_t status_i,
    output led_pattern_t pattern_o
);

    led_pattern_t pat_d;

    always_comb begin
        pat_d = '{colour: RGB_RED, flash: 1'b0};
        if (status_i.image == IMG_NONE || status_i.image == IMG_RSVD) begin
            pat_d = '{colour: RGB_RED, flash: 1'b0};
        end else if (status_i.fail) begin
            pat_d = '{colour: RGB_RED, flash: 1'b1};
        end else if (status_i.image == IMG_SAFE) begin
            pat_d = '{colour: RGB_BLUE, flash: !status_i.gen2};
        end else if (status_i.x4) begin
            pat_d = '{colour: RGB_GREEN, flash: !status_i.gen2};
        end else begin
            pat_d = '{colour: RGB_AMBER, flash: !status_i.gen2};
        end
    end

    assign pattern_o = pat_d;

    always_comb begin
        // Blue is exclusive of red and green.
        assert_blue_alone_R6: assert (!pat_d.colour.blue || (!pat_d.colour.red && !pat_d.colour.green));
        // Some colour is always chosen.
        assert_colour_set_R1: assert (pat_d.colour != RGB_OFF);
    end

endmodule

// File: rtl/hll_flasher.sv
module hll_flasher #(
    parameter int HALF_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic lit_o
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt   = '0;
            st_d.phase = 1'b1;
        end else if (st_q.cnt == TOP) begin
            st_d.cnt   = '0;
            st_d.phase = !st_q.phase;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lit_o = st_q.phase;

    // Restart wins over a terminal count and opens a fresh lit half.
    assert_restart_lit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.phase && st_q.cnt == '0));

    // Phase holds inside a half period.
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && st_q.cnt != TOP) |=> $stable(st_q.phase));

    // Phase flips at the end of a half period.
    assert_phase_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && st_q.cnt == TOP) |=> (st_q.phase != $past(st_q.phase)));

    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP);

endmodule

// File: rtl/host_link_led.sv
module host_link_led
    import host_link_led_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int FLASH_HZ = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fw_image_i,
    input  logic       link_gen2_i,
    input  logic       lanes_x4_i,
    input  logic       train_fail_i,
    output logic       led_red_o,
    output logic       led_green_o,
    output logic       led_blue_o
);

    localparam int HALF_RAW = CLK_HZ / (2 * FLASH_HZ);
    localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

    link_status_t status_in;
    link_status_t status_q;
    logic         change;
    led_pattern_t pattern;
    logic         lit;
    rgb_t         drive;

    always_comb begin
        status_in       = STATUS_RESET;
        status_in.image = fw_image_e'(fw_image_i);
        status_in.gen2  = link_gen2_i;
        status_in.x4    = lanes_x4_i;
        status_in.fail  = train_fail_i;
    end

    hll_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_in),
        .status_o (status_q),
        .change_o (change)
    );

    hll_priority u_priority (
        .status_i  (status_q),
        .pattern_o (pattern)
    );

    hll_flasher #(.HALF_CYC(HALF_CYC)) u_flasher (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (change),
        .lit_o     (lit)
    );

    always_comb begin
        drive = (pattern.flash && !lit) ? RGB_OFF : pattern.colour;
    end

    assign led_red_o   = drive.red;
    assign led_green_o = drive.green;
    assign led_blue_o  = drive.blue;

    // No image sampled: steady red only.
    assert_no_image_red_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q.image == IMG_NONE || status_q.image == IMG_RSVD) |->
        (led_red_o && !led_green_o && !led_blue_o));

    // Failure with an image: never green or blue.
    assert_fail_red_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q.fail && status_q.image != IMG_NONE) |-> (!led_green_o && !led_blue_o));

    // A new status always starts lit.
    assert_new_status_lit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> (led_red_o || led_green_o || led_blue_o));

    // Second-generation speed without failure never blinks.
    assert_gen2_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q.gen2 && !status_q.fail) |-> (led_red_o || led_green_o || led_blue_o));

endmodule

// File: tb/tb_host_link_led.sv
module tb_host_link_led;

    localparam int CLK_HZ   = 40;
    localparam int FLASH_HZ = 2;
    localparam int HALF     = CLK_HZ / (2 * FLASH_HZ);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fw = 2'b00;
    logic       gen2 = 1'b0;
    logic       x4 = 1'b0;
    logic       fail = 1'b0;
    logic       r, g, b;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    host_link_led #(.CLK_HZ(CLK_HZ), .FLASH_HZ(FLASH_HZ)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fw_image_i   (fw),
        .link_gen2_i  (gen2),
        .lanes_x4_i   (x4),
        .train_fail_i (fail),
        .led_red_o    (r),
        .led_green_o  (g),
        .led_blue_o   (b)
    );

    // Behavioural reference: sampled status, prescaler count, lit flag.
    logic [4:0] m_st  = 5'b0;
    int         m_cnt = 0;
    bit         m_lit = 1'b1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st  <= 5'b0;
            m_cnt <= 0;
            m_lit <= 1'b1;
        end else begin
            if ({fw, gen2, x4, fail} != m_st) begin
                m_cnt <= 0;
                m_lit <= 1'b1;
            end else if (m_cnt == HALF - 1) begin
                m_cnt <= 0;
                m_lit <= !m_lit;
            end else begin
                m_cnt <= m_cnt + 1;
            end
            m_st <= {fw, gen2, x4, fail};
        end
    end

    function automatic void expect_of(input logic [4:0] s, input bit lit_now,
                                      output logic [2:0] rgb, output string tag);
        logic [2:0] col;
        bit blink;
        if (s[4:3] == 2'b00 || s[4:3] == 2'b11) begin
            col = 3'b100; blink = 0; tag = "R1";
        end else if (s[0]) begin
            col = 3'b100; blink = 1; tag = "R2";
        end else if (s[4:3] == 2'b10) begin
            col = 3'b001; blink = !s[2]; tag = "R6";
        end else if (s[1]) begin
            col = 3'b010; blink = !s[2]; tag = s[2] ? "R3" : "R4";
        end else begin
            col = 3'b110; blink = !s[2]; tag = "R5";
        end
        rgb = (blink && !lit_now) ? 3'b000 : col;
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual rgb=%b expected rgb=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [2:0] e;
            string t;
            expect_of(m_st, m_lit, e, t);
            check(t, {r, g, b}, e);
        end
    end

    task automatic drive(input logic [1:0] f, input logic s2, input logic l4, input logic tf);
        fw = f; gen2 = s2; x4 = l4; fail = tf;
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        int lit_cnt;
        int dark_cnt;
        hold(3);
        check("R9 reset", {r, g, b}, 3'b100);
        rst_n = 1'b1;
        hold(2);

        // R3 with one-cycle latency (R8)
        drive(2'b01, 1, 1, 0);
        @(negedge clk);
        check("R8 latency", {r, g, b}, 3'b010);
        hold(2 * HALF);

        // R4 duty: HALF lit then HALF dark (R7)
        drive(2'b01, 0, 1, 0);
        lit_cnt = 0; dark_cnt = 0;
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            if ({r, g, b} == 3'b010) lit_cnt++;
        end
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            if ({r, g, b} == 3'b000) dark_cnt++;
        end
        check("R7 lit half", lit_cnt[2:0] == 3'(HALF) && lit_cnt == HALF ? 3'b001 : 3'b000, 3'b001);
        check("R7 dark half", dark_cnt == HALF ? 3'b001 : 3'b000, 3'b001);
        hold(HALF);

        // R5 amber
        drive(2'b01, 1, 0, 0); hold(HALF + 3);
        drive(2'b01, 0, 0, 0); hold(3 * HALF);

        // R6 safe, lane width ignored
        drive(2'b10, 1, 0, 0); hold(HALF);
        drive(2'b10, 1, 1, 0); @(negedge clk);
        check("R6 x4 ignored", {r, g, b}, 3'b001);
        drive(2'b10, 0, 0, 0); hold(3 * HALF);

        // R2 failure over every image/speed
        drive(2'b01, 1, 1, 1); hold(3 * HALF);
        drive(2'b10, 1, 0, 1); hold(HALF + 2);

        // R1 no image and reserved code dominate
        drive(2'b00, 0, 1, 1); hold(2 * HALF);
        drive(2'b11, 0, 0, 1); hold(2 * HALF);

        // Collision while lit: change lands on the terminal edge
        drive(2'b01, 0, 1, 0);
        while (!(m_cnt == HALF - 2 && m_lit)) @(negedge clk);
        @(negedge clk);
        drive(2'b10, 0, 1, 0);
        @(negedge clk);
        check("R8 restart beats toggle (lit)", {r, g, b}, 3'b001);
        hold(HALF - 1);
        check("R8 full lit half kept", {r, g, b}, 3'b001);

        // Collision while dark
        while (!(m_cnt == HALF - 2 && !m_lit)) @(negedge clk);
        @(negedge clk);
        drive(2'b01, 0, 0, 0);
        @(negedge clk);
        check("R8 restart beats toggle (dark)", {r, g, b}, 3'b110);
        hold(2 * HALF);

        // Change mid dark half restarts lit
        drive(2'b10, 0, 0, 1);
        while (m_lit) @(negedge clk);
        hold(2);
        drive(2'b01, 0, 1, 1);
        @(negedge clk);
        check("R8 mid-dark restart", {r, g, b}, 3'b100);
        hold(HALF);

        // Reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async reset", {r, g, b}, 3'b100);
        hold(2);
        check("R9 held in reset", {r, g, b}, 3'b100);
        rst_n = 1'b1;
        hold(2 * HALF);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL R8 watchdog: actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule